// File: doc/BRIEF.md
# Program Counter with Return Stack

This unit holds the 13-bit instruction address of a small 8-bit RISC core. Each instruction cycle the decoder raises one or more control strobes: step to the next word, jump to an 11-bit target, call a subroutine, return from one, accept an interrupt, write the low address byte from the data bus, or write a 5-bit high-address holding register. The unit presents the full address, the 10-bit word address that goes to the program memory, and the low address byte as a readable value.

The address space is 8K words, but only 1K words of memory are fitted, so the fetch address uses only the ten low bits and higher addresses alias onto the same words. Jumps and calls take their two top address bits from the holding register. A write to the low address byte takes all five upper bits from that register. Nothing copies address bits back into the holding register. Return addresses are kept in an eight-entry circular stack that never reports overflow or underflow.

Top module: `pc_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the address becomes 0000h and the high holding register becomes 0.
- R2: A step (`inc_en` with no higher-priority strobe) adds one to the 13-bit address, and 1FFFh wraps to 0000h.
- R3: `fetch_addr` always equals address bits 9:0, so 0020h, 0420h and 1C20h all fetch word 020h. `pcl_out` always equals address bits 7:0.
- R4: A jump (`jmp_en`) loads the address with holding-register bits 4:3 as address bits 12:11 and `tgt` as bits 10:0.
- R5: A low-byte write (`pcl_we`) loads address bits 7:0 from `din` and bits 12:8 from the holding register, both in the same cycle.
- R6: `hi_we` loads `din[4:0]` into the holding register and does not change the address. No address load ever changes the holding register.
- R7: A call (`call_en`) pushes the current address plus one and then loads the address as a jump does. A return (`ret_en`) loads the most recently pushed value and pops it.
- R8: The stack has eight entries and wraps. A ninth push without a pop overwrites the oldest entry. Pops past empty continue around the ring with no error flag.
- R9: An interrupt acknowledge (`irq_ack`) pushes the current address unchanged and loads 0004h.
- R10: The address strobes take effect in this priority order: `irq_ack`, `call_en`, `jmp_en`, `ret_en`, `pcl_we`, `inc_en`. `hi_we` acts independently of all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per instruction cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| inc_en | input | 1 | Step to the next word |
| jmp_en | input | 1 | Jump to the target |
| call_en | input | 1 | Push the return address and jump to the target |
| ret_en | input | 1 | Pop the top of the stack into the address |
| pcl_we | input | 1 | Write the low address byte from the data bus |
| hi_we | input | 1 | Write the high holding register from the data bus |
| irq_ack | input | 1 | Push the current address and take the interrupt vector |
| tgt | input | 11 | Jump or call target taken from the instruction word |
| din | input | 8 | Data bus value |
| pc | output | 13 | Full program address |
| fetch_addr | output | 10 | Word address sent to program memory |
| pcl_out | output | 8 | Low address byte, readable |

## Verification
The hardest state to reach is a stack that has wrapped in both directions. To get there, the stimulus makes nine nested calls from distinct addresses, which overwrites the oldest entry. It then makes nine returns: the first pops the overwritten slot, and the last pops past empty. Aliasing of the fetch address is reached by setting the holding register to high values and then writing the low byte, which puts the address far above the fitted memory. Collisions between strobes are driven as deliberate simultaneous pulses, such as an interrupt acknowledge together with a step.

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int PC_W    = 13,
  parameter int FETCH_W = 10,
  parameter int TGT_W   = 11,
  parameter int DEPTH   = 8,
  parameter logic [PC_W-1:0] RST_VEC = '0,
  parameter logic [PC_W-1:0] IRQ_VEC = PC_W'(4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic              jmp_en,
  input  logic              call_en,
  input  logic              ret_en,
  input  logic              pcl_we,
  input  logic              hi_we,
  input  logic              irq_ack,
  input  logic [TGT_W-1:0]  tgt,
  input  logic [7:0]        din,
  output logic [PC_W-1:0]   pc,
  output logic [FETCH_W-1:0] fetch_addr,
  output logic [7:0]        pcl_out
);
  localparam int HI_W  = PC_W - 8;
  localparam int TOP_W = PC_W - TGT_W;
  localparam int SP_W  = $clog2(DEPTH);

  logic [HI_W-1:0]  hi_q;
  logic [PC_W-1:0]  stk [DEPTH];
  logic [SP_W-1:0]  sp;
  logic [SP_W-1:0]  sp_dn;
  logic [PC_W-1:0]  pc_nxt, push_val, br_tgt;
  logic             push, pop;

  assign sp_dn      = sp - SP_W'(1);
  assign br_tgt     = {hi_q[HI_W-1 -: TOP_W], tgt};
  assign fetch_addr = pc[FETCH_W-1:0];
  assign pcl_out    = pc[7:0];

  always_comb begin
    pc_nxt   = pc;
    push     = 1'b0;
    pop      = 1'b0;
    push_val = pc + PC_W'(1);
    if (irq_ack) begin
      pc_nxt   = IRQ_VEC;
      push     = 1'b1;
      push_val = pc;
    end else if (call_en) begin
      pc_nxt = br_tgt;
      push   = 1'b1;
    end else if (jmp_en) begin
      pc_nxt = br_tgt;
    end else if (ret_en) begin
      pc_nxt = stk[sp_dn];
      pop    = 1'b1;
    end else if (pcl_we) begin
      pc_nxt = {hi_q, din};
    end else if (inc_en) begin
      pc_nxt = pc + PC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc   <= RST_VEC;
      hi_q <= '0;
      sp   <= '0;
    end else begin
      pc <= pc_nxt;
      if (hi_we) hi_q <= din[HI_W-1:0];
      if (push) begin
        stk[sp] <= push_val;
        sp      <= sp + SP_W'(1);
      end else if (pop) begin
        sp <= sp_dn;
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (pc == RST_VEC && hi_q == '0));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !irq_ack && !call_en && !jmp_en && !ret_en && !pcl_we)
    |=> pc == PC_W'($past(pc) + PC_W'(1)));

  assert_jump_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_en && !irq_ack && !call_en) |=> pc[TGT_W-1:0] == $past(tgt));

  assert_pcl_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pcl_we && !irq_ack && !call_en && !jmp_en && !ret_en)
    |=> pc[7:0] == $past(din));

  assert_hi_only_when_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_we |=> $stable(hi_q));

  assert_hi_keeps_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !irq_ack && !call_en && !jmp_en && !ret_en && !pcl_we && !inc_en)
    |=> $stable(pc));

  assert_irq_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> pc == IRQ_VEC);
endmodule

// File: tb/pc_unit_tb.sv
module pc_unit_tb;
  logic clk = 0, rst_n = 0;
  logic inc_en = 0, jmp_en = 0, call_en = 0, ret_en = 0, pcl_we = 0, hi_we = 0, irq_ack = 0;
  logic [10:0] tgt = '0;
  logic [7:0]  din = '0;
  logic [12:0] pc;
  logic [9:0]  fetch_addr;
  logic [7:0]  pcl_out;

  int checks = 0, errors = 0;

  typedef struct { logic [12:0] pc; string tag; } exp_t;
  exp_t exp_q[$];

  logic [12:0] m_pc = 0;
  logic [4:0]  m_hi = 0;
  logic [12:0] m_stk [8];
  int          m_sp = 0;

  pc_unit u_dut (.clk, .rst_n, .inc_en, .jmp_en, .call_en, .ret_en, .pcl_we,
                 .hi_we, .irq_ack, .tgt, .din, .pc, .fetch_addr, .pcl_out);

  always #10 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic m_push(input logic [12:0] v);
    m_stk[m_sp] = v;
    m_sp = (m_sp + 1) % 8;
  endtask

  // ops bits: {irq, call, jmp, ret, pcl, hi, inc}
  task automatic drive(input logic [6:0] ops, input logic [10:0] t,
                       input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    {irq_ack, call_en, jmp_en, ret_en, pcl_we, hi_we, inc_en} = ops;
    tgt = t; din = d;
    if (ops[6]) begin m_push(m_pc); m_pc = 13'h0004; end
    else if (ops[5]) begin m_push(m_pc + 13'd1); m_pc = {m_hi[4:3], t}; end
    else if (ops[4]) m_pc = {m_hi[4:3], t};
    else if (ops[3]) begin m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp]; end
    else if (ops[2]) m_pc = {m_hi, d};
    else if (ops[0]) m_pc = m_pc + 13'd1;
    if (ops[1]) m_hi = d[4:0];
    e.pc = m_pc; e.tag = tag;
    exp_q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(pc, e.pc, e.tag);
      chk(fetch_addr, e.pc[9:0], "R3 fetch");
      chk(pcl_out, e.pc[7:0], "R3 low byte");
    end
  end

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pc, 13'h0000, "R1 reset pc");
    rst_n = 1;
    drive(7'b0000100, 0, 8'h37, "R1 R5 latch zero after reset");
    drive(7'b0000001, 0, 0, "R2 step");
    drive(7'b0000001, 0, 0, "R2 step");
    drive(7'b0000010, 0, 8'h18, "R6 hi write keeps pc");
    drive(7'b0010000, 11'h123, 0, "R4 jump");
    drive(7'b0000100, 0, 8'h20, "R5 low write");
    drive(7'b0000010, 0, 8'h1C, "R6 hi write");
    drive(7'b0000100, 0, 8'h20, "R3 R5 alias 1C20");
    drive(7'b0000110, 0, 8'h04, "R5 R6 same-cycle uses old hi");
    drive(7'b0000110, 0, 8'hFF, "R6 hi reload");
    drive(7'b0000100, 0, 8'hFF, "R5 to 1FFF");
    drive(7'b0000001, 0, 0, "R2 wrap to 0000");
    drive(7'b0000100, 0, 8'h55, "R6 hi never reloaded from pc");
    drive(7'b0000010, 0, 8'h00, "R6 hi clear");
    for (int i = 0; i < 9; i++)
      drive(7'b0100000, 11'(16 * (i + 1)), 0, "R7 R8 call");
    for (int i = 0; i < 9; i++)
      drive(7'b0001000, 0, 0, "R7 R8 return wrap");
    drive(7'b0010000, 11'h2AA, 0, "R4 jump");
    drive(7'b1000001, 0, 0, "R9 R10 irq over step");
    drive(7'b0001000, 0, 0, "R9 return from irq");
    drive(7'b0110000, 11'h050, 0, "R10 call over jump");
    drive(7'b0011100, 11'h070, 8'h99, "R10 jump over ret and pcl");
    drive(7'b0001101, 0, 8'h11, "R10 ret over pcl and step");
    drive(7'b0000101, 0, 8'h42, "R10 pcl over step");
    drive(7'b0000000, 0, 0, "R10 idle holds");
    wait (exp_q.size() == 0);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(pc, 13'h0000, "R1 mid-run reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule